// File: doc/BRIEF.md
# Transfer Request Decoder and Arbiter

This block sits between a master processor and up to four slave signal processors. The master hands it 48-bit transfer request words, one per cycle. Each word names a requesting source and a target processor. It also gives a direction, a per-block length with a unit flag, a block count, a priority and two pass-through fields. Bit 35 is a parity bit, and the block checks it.

A word that fails the parity check, names an index outside the fitted processors, or finds its source's slot already taken is refused. The block then raises a one-cycle re-request pulse toward the master. A word that passes is parked in a pending slot kept per source. When its target is idle, the block issues a one-cycle command that carries the direction, both indices and the total transfer length. It also enables the target's FIFO channel. The channel stays enabled until the target reports completion on its done input.

When several parked requests could be served in the same cycle, the block serves the one with the highest priority value first. Among equal priorities, the lowest source index goes first. Only one command is issued per cycle.

Top module: `xfer_req_arbiter`

## Requirements
- R1: After reset, cmd_valid_o, retry_o and every bit of chan_en_o are 0.
- R2: The word must have an even number of ones in bits 0..35, where bit 35 is the parity bit. A word with an odd count raises retry_o in the cycle after it is presented, and it produces no command.
- R3: An accepted word whose target is idle produces cmd_valid_o for exactly one cycle, two cycles after the word is presented. The command gives cmd_recv_o = bit 0 (1 means the target receives, 0 means it sends), cmd_src_o = bits 1..3 and cmd_tgt_o = bits 4..6.
- R4: cmd_total_o equals the block count (bits 20..27) times the length (bits 7..18). cmd_kilo_o equals bit 19, where 1 means the total counts units of 1024 and 0 means single units.
- R5: cmd_state_o carries bits 31..34 and cmd_user_o carries bits 36..47 of the word unchanged.
- R6: chan_en_o[t] rises together with the command to target t and falls in the cycle after done_i[t] pulses. No command goes to a target while its channel is enabled.
- R7: Several pending requests may wait for one target. When that target is released, the request with the largest priority (bits 28..30) is served first.
- R8: Among pending requests of equal priority, the lowest source index is served first.
- R9: A word is refused and retry_o pulses in the next cycle in three cases: its source already holds a pending request, its source index is NUM_DSP or more, or its target index is NUM_DSP or more. A refused word leaves the pending request intact.
- R10: A new word from a source is accepted, with no retry, in the same cycle that source's pending request is granted.
- R11: At most one command is issued per cycle. Requests that are eligible together are served on consecutive cycles in priority order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Request word present this cycle |
| req_word_i | input | 48 | Request word |
| done_i | input | NUM_DSP | Per-target completion pulse |
| retry_o | output | 1 | Re-request pulse to the master |
| cmd_valid_o | output | 1 | Command pulse |
| cmd_recv_o | output | 1 | 1 = target receives, 0 = target sends |
| cmd_src_o | output | 3 | Requesting source index |
| cmd_tgt_o | output | 3 | Target index |
| cmd_total_o | output | 20 | Block count times length |
| cmd_kilo_o | output | 1 | Total counts units of 1024 |
| cmd_state_o | output | 4 | State field passed through |
| cmd_user_o | output | 12 | User field passed through |
| chan_en_o | output | NUM_DSP | Per-target FIFO channel enable |

## Verification
Two functions can fall in the same cycle: a source's parked request being granted, and a new word from that same source arriving. The bench provokes this by presenting two words from one source on back-to-back cycles toward an idle target. The second word lands exactly as the first is granted. The bench judges the result by the absence of retry on the second word. It also checks that, after the target's done pulse, a second command appears carrying the second word's length.

// File: rtl/xra_pkg.sv
// Package: field layout of the request word and the decoded request type.
// Assumes a fixed 48-bit word layout; positions are decoded by the arbiter.
package xra_pkg;
    localparam int WORD_W  = 48;
    localparam int IDX_FW  = 3;
    localparam int LEN_W   = 12;
    localparam int BLK_W   = 8;
    localparam int PRIO_W  = 3;
    localparam int STATE_W = 4;
    localparam int USER_W  = 12;
    localparam int TOT_W   = LEN_W + BLK_W;

    localparam int B_DIR   = 0;
    localparam int B_SRC   = 1;
    localparam int B_TGT   = 4;
    localparam int B_LEN   = 7;
    localparam int B_KILO  = 19;
    localparam int B_BLK   = 20;
    localparam int B_PRIO  = 28;
    localparam int B_STATE = 31;
    localparam int B_PAR   = 35;
    localparam int B_USER  = 36;

    typedef struct packed {
        logic               recv;
        logic [IDX_FW-1:0]  src;
        logic [IDX_FW-1:0]  tgt;
        logic [PRIO_W-1:0]  prio;
        logic               kilo;
        logic [TOT_W-1:0]   total;
        logic [STATE_W-1:0] state;
        logic [USER_W-1:0]  user;
    } req_t;
endpackage

// File: rtl/xra_decode.sv
// Decoder: splits a request word into fields, computes the total length,
// checks even parity over bits 0..35 and checks that both indices exist.
// Assumes NUM_DSP <= 8.
module xra_decode
    import xra_pkg::*;
#(
    parameter int NUM_DSP = 4
) (
    input  logic [WORD_W-1:0] word_i,
    output req_t              req_o,
    output logic              par_ok_o,
    output logic              idx_ok_o
);
    logic [LEN_W-1:0] len;
    logic [BLK_W-1:0] blk;

    // Field extraction and total-length product.
    always_comb begin
        len            = word_i[B_LEN +: LEN_W];
        blk            = word_i[B_BLK +: BLK_W];
        req_o.recv     = word_i[B_DIR];
        req_o.src      = word_i[B_SRC +: IDX_FW];
        req_o.tgt      = word_i[B_TGT +: IDX_FW];
        req_o.prio     = word_i[B_PRIO +: PRIO_W];
        req_o.kilo     = word_i[B_KILO];
        req_o.state    = word_i[B_STATE +: STATE_W];
        req_o.user     = word_i[B_USER +: USER_W];
        req_o.total    = TOT_W'(blk) * TOT_W'(len);
    end

    // Parity and index range checks.
    always_comb begin
        par_ok_o = ~(^word_i[B_PAR:0]);
        idx_ok_o = (int'(word_i[B_SRC +: IDX_FW]) < NUM_DSP) &&
                   (int'(word_i[B_TGT +: IDX_FW]) < NUM_DSP);
    end
endmodule

// File: rtl/xra_slots.sv
// Pending slots: one parked request per source. A write and a grant of the
// same slot in one cycle keep the new request. Assumes wr_en_i only when free.
module xra_slots
    import xra_pkg::*;
#(
    parameter int NUM_DSP = 4,
    localparam int IDX_W  = (NUM_DSP > 1) ? $clog2(NUM_DSP) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en_i,
    input  logic [IDX_W-1:0]              wr_idx_i,
    input  req_t                          wr_req_i,
    input  logic                          gnt_i,
    input  logic [IDX_W-1:0]              gnt_idx_i,
    output logic [NUM_DSP-1:0]            vld_o,
    output logic [NUM_DSP-1:0]            free_o,
    output req_t [NUM_DSP-1:0]            req_o
);
    for (genvar i = 0; i < NUM_DSP; i++) begin : g_slot
        logic wr_here;
        logic gnt_here;
        assign wr_here  = wr_en_i && (wr_idx_i == IDX_W'(i));
        assign gnt_here = gnt_i && (gnt_idx_i == IDX_W'(i));

        // Slot occupancy and contents.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_o[i] <= 1'b0;
                req_o[i] <= '0;
            end else if (wr_here) begin
                vld_o[i] <= 1'b1;
                req_o[i] <= wr_req_i;
            end else if (gnt_here) begin
                vld_o[i] <= 1'b0;
            end
        end

        // Slot can take a new word now.
        assign free_o[i] = ~vld_o[i] | gnt_here;
    end
endmodule

// File: rtl/xra_pick.sv
// Picker: among valid slots whose target is idle, chooses the highest
// priority; ties go to the lowest slot index. Purely combinational.
module xra_pick
    import xra_pkg::*;
#(
    parameter int NUM_DSP = 4,
    localparam int IDX_W  = (NUM_DSP > 1) ? $clog2(NUM_DSP) : 1
) (
    input  logic [NUM_DSP-1:0]              vld_i,
    input  logic [NUM_DSP-1:0][IDX_W-1:0]   tgt_i,
    input  logic [NUM_DSP-1:0][PRIO_W-1:0]  prio_i,
    input  logic [NUM_DSP-1:0]              busy_i,
    output logic                            gnt_o,
    output logic [IDX_W-1:0]                gnt_idx_o
);
    logic [PRIO_W-1:0] best_p;

    // Ascending scan; strict compare keeps the lower index on ties.
    always_comb begin
        gnt_o     = 1'b0;
        gnt_idx_o = '0;
        best_p    = '0;
        for (int i = 0; i < NUM_DSP; i++) begin
            if (vld_i[i] && !busy_i[tgt_i[i]] &&
                (!gnt_o || prio_i[i] > best_p)) begin
                gnt_o     = 1'b1;
                gnt_idx_o = IDX_W'(i);
                best_p    = prio_i[i];
            end
        end
    end
endmodule

// File: rtl/xfer_req_arbiter.sv
// Top: accepts request words, refuses bad ones with a re-request pulse,
// parks good ones per source, and grants one idle target per cycle.
// Assumes done_i pulses only for an enabled channel (others are ignored).
module xfer_req_arbiter
    import xra_pkg::*;
#(
    parameter int NUM_DSP = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid_i,
    input  logic [47:0]         req_word_i,
    input  logic [NUM_DSP-1:0]  done_i,
    output logic                retry_o,
    output logic                cmd_valid_o,
    output logic                cmd_recv_o,
    output logic [2:0]          cmd_src_o,
    output logic [2:0]          cmd_tgt_o,
    output logic [19:0]         cmd_total_o,
    output logic                cmd_kilo_o,
    output logic [3:0]          cmd_state_o,
    output logic [11:0]         cmd_user_o,
    output logic [NUM_DSP-1:0]  chan_en_o
);
    localparam int IDX_W = (NUM_DSP > 1) ? $clog2(NUM_DSP) : 1;

    req_t                            dec_req;
    logic                            par_ok;
    logic                            idx_ok;
    logic                            accept;
    logic [NUM_DSP-1:0]              slot_vld;
    logic [NUM_DSP-1:0]              slot_free;
    req_t [NUM_DSP-1:0]              slot_req;
    logic [NUM_DSP-1:0][IDX_W-1:0]   slot_tgt;
    logic [NUM_DSP-1:0][PRIO_W-1:0]  slot_prio;
    logic                            gnt;
    logic [IDX_W-1:0]                gnt_idx;
    logic [NUM_DSP-1:0]              busy_q;
    req_t                            win;

    xra_decode #(.NUM_DSP(NUM_DSP)) u_dec (
        .word_i   (req_word_i),
        .req_o    (dec_req),
        .par_ok_o (par_ok),
        .idx_ok_o (idx_ok)
    );

    // Acceptance needs parity, valid indices and a free source slot.
    always_comb begin
        accept = req_valid_i && par_ok && idx_ok &&
                 slot_free[IDX_W'(dec_req.src)];
    end

    xra_slots #(.NUM_DSP(NUM_DSP)) u_slots (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (accept),
        .wr_idx_i  (IDX_W'(dec_req.src)),
        .wr_req_i  (dec_req),
        .gnt_i     (gnt),
        .gnt_idx_i (gnt_idx),
        .vld_o     (slot_vld),
        .free_o    (slot_free),
        .req_o     (slot_req)
    );

    // Slice target and priority out of the parked requests for the picker.
    for (genvar i = 0; i < NUM_DSP; i++) begin : g_fields
        assign slot_tgt[i]  = IDX_W'(slot_req[i].tgt);
        assign slot_prio[i] = slot_req[i].prio;
    end

    xra_pick #(.NUM_DSP(NUM_DSP)) u_pick (
        .vld_i     (slot_vld),
        .tgt_i     (slot_tgt),
        .prio_i    (slot_prio),
        .busy_i    (busy_q),
        .gnt_o     (gnt),
        .gnt_idx_o (gnt_idx)
    );

    assign win = slot_req[gnt_idx];

    // Re-request pulse, command register and per-target busy state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            retry_o     <= 1'b0;
            cmd_valid_o <= 1'b0;
            cmd_recv_o  <= 1'b0;
            cmd_src_o   <= '0;
            cmd_tgt_o   <= '0;
            cmd_total_o <= '0;
            cmd_kilo_o  <= 1'b0;
            cmd_state_o <= '0;
            cmd_user_o  <= '0;
            busy_q      <= '0;
        end else begin
            retry_o     <= req_valid_i && !accept;
            cmd_valid_o <= gnt;
            if (gnt) begin
                cmd_recv_o  <= win.recv;
                cmd_src_o   <= win.src;
                cmd_tgt_o   <= win.tgt;
                cmd_total_o <= win.total;
                cmd_kilo_o  <= win.kilo;
                cmd_state_o <= win.state;
                cmd_user_o  <= win.user;
            end
            busy_q <= (busy_q & ~done_i) |
                      (gnt ? (NUM_DSP'(1) << slot_tgt[gnt_idx]) : '0);
        end
    end

    assign chan_en_o = busy_q;
endmodule

// File: rtl/xra_checks.sv
// Checker: temporal properties on the arbiter ports, bound to the top.
module xra_checks #(
    parameter int NUM_DSP = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid_i,
    input logic [47:0]        req_word_i,
    input logic [NUM_DSP-1:0] done_i,
    input logic               retry_o,
    input logic               cmd_valid_o,
    input logic [2:0]         cmd_tgt_o,
    input logic [NUM_DSP-1:0] chan_en_o
);
    a_r2_bad_parity_retry: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && ^req_word_i[35:0]) |=> retry_o);

    a_r6_cmd_enables_channel: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> (chan_en_o & (NUM_DSP'(1) << cmd_tgt_o)) != '0);

    a_r6_no_cmd_to_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> ($past(chan_en_o) & (NUM_DSP'(1) << cmd_tgt_o)) == '0);

    a_r6_release_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (|(done_i & chan_en_o)) |=> ((chan_en_o & $past(done_i & chan_en_o)) == '0));

    a_r11_one_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chan_en_o & ~$past(chan_en_o)));

    a_r6_rise_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (|(chan_en_o & ~$past(chan_en_o))) |-> cmd_valid_o);
endmodule

bind xfer_req_arbiter xra_checks #(.NUM_DSP(NUM_DSP)) u_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_word_i  (req_word_i),
    .done_i      (done_i),
    .retry_o     (retry_o),
    .cmd_valid_o (cmd_valid_o),
    .cmd_tgt_o   (cmd_tgt_o),
    .chan_en_o   (chan_en_o)
);

// File: tb/xfer_req_arbiter_tb_top.sv
// Directed bench: one task per scenario, each checking its own results.
module xfer_req_arbiter_tb_top;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         req_valid_i;
    logic [47:0]  req_word_i;
    logic [N-1:0] done_i;
    logic         retry_o, cmd_valid_o, cmd_recv_o, cmd_kilo_o;
    logic [2:0]   cmd_src_o, cmd_tgt_o;
    logic [19:0]  cmd_total_o;
    logic [3:0]   cmd_state_o;
    logic [11:0]  cmd_user_o;
    logic [N-1:0] chan_en_o;

    int n_run  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    always #10 clk = ~clk;

    xfer_req_arbiter #(.NUM_DSP(N)) dut_i (.*);

    // Build a request word; bad=1 flips the parity bit.
    function automatic logic [47:0] mk(input bit recv, input int src, input int tgt,
                                       input int len, input bit kilo, input int blk,
                                       input int prio, input int st, input int usr,
                                       input bit bad);
        logic [47:0] w;
        w = '0;
        w[0]      = recv;
        w[3:1]    = 3'(src);
        w[6:4]    = 3'(tgt);
        w[18:7]   = 12'(len);
        w[19]     = kilo;
        w[27:20]  = 8'(blk);
        w[30:28]  = 3'(prio);
        w[34:31]  = 4'(st);
        w[47:36]  = 12'(usr);
        w[35]     = (^w[34:0]) ^ bad;
        return w;
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req_valid_i = 1'b0; req_word_i = '0; done_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Present a word for one cycle; returns at the negedge after its edge.
    task automatic send(input logic [47:0] w);
        req_valid_i = 1'b1; req_word_i = w;
        @(negedge clk);
        req_valid_i = 1'b0;
    endtask

    task automatic done_pulse(input int t);
        done_i = N'(1) << t;
        @(negedge clk);
        done_i = '0;
    endtask

    task automatic chk_cmd(input string req, input int src, input int tgt);
        chk(req, "cmd_valid", cmd_valid_o, 1);
        chk(req, "cmd_src", cmd_src_o, src);
        chk(req, "cmd_tgt", cmd_tgt_o, tgt);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "cmd_valid", cmd_valid_o, 0);
        chk("R1", "retry", retry_o, 0);
        chk("R1", "chan_en", chan_en_o, 0);
    endtask

    task automatic t_basic();
        do_reset();
        send(mk(1, 0, 2, 100, 0, 3, 2, 5, 'hABC, 0));
        chk("R3", "retry", retry_o, 0);
        chk("R3", "early cmd", cmd_valid_o, 0);
        @(negedge clk);
        chk_cmd("R3", 0, 2);
        chk("R3", "recv", cmd_recv_o, 1);
        chk("R4", "total", cmd_total_o, 300);
        chk("R4", "kilo", cmd_kilo_o, 0);
        chk("R5", "state", cmd_state_o, 5);
        chk("R5", "user", cmd_user_o, 'hABC);
        chk("R6", "chan_en", chan_en_o, 4);
        @(negedge clk);
        chk("R3", "pulse width", cmd_valid_o, 0);
        done_pulse(2);
        chk("R6", "release", chan_en_o, 0);
    endtask

    task automatic t_parity();
        do_reset();
        send(mk(1, 1, 1, 7, 0, 1, 0, 0, 0, 1));
        chk("R2", "retry", retry_o, 1);
        @(negedge clk);
        chk("R2", "no cmd", cmd_valid_o, 0);
        chk("R2", "chan_en", chan_en_o, 0);
        chk("R2", "retry cleared", retry_o, 0);
    endtask

    task automatic t_max_len();
        do_reset();
        send(mk(0, 3, 0, 4095, 1, 255, 7, 15, 'hFFF, 0));
        @(negedge clk);
        chk_cmd("R3", 3, 0);
        chk("R3", "recv=0 send", cmd_recv_o, 0);
        chk("R4", "max total", cmd_total_o, 4095 * 255);
        chk("R4", "kilo", cmd_kilo_o, 1);
        chk("R5", "user", cmd_user_o, 'hFFF);
    endtask

    task automatic t_priority();
        do_reset();
        send(mk(1, 0, 1, 1, 0, 1, 0, 0, 0, 0));
        @(negedge clk);
        chk_cmd("R6", 0, 1);
        send(mk(1, 1, 1, 2, 0, 1, 2, 0, 0, 0));
        chk("R6", "busy hold", cmd_valid_o, 0);
        send(mk(1, 2, 1, 3, 0, 1, 5, 0, 0, 0));
        chk("R6", "busy hold", cmd_valid_o, 0);
        send(mk(1, 3, 1, 4, 0, 1, 5, 0, 0, 0));
        chk("R6", "busy hold", cmd_valid_o, 0);
        @(negedge clk);
        chk("R6", "still busy", cmd_valid_o, 0);
        done_pulse(1);
        chk("R6", "released", chan_en_o, 0);
        @(negedge clk);
        chk_cmd("R7", 2, 1);
        chk("R7", "total", cmd_total_o, 3);
        done_pulse(1);
        @(negedge clk);
        chk_cmd("R8", 3, 1);
        done_pulse(1);
        @(negedge clk);
        chk_cmd("R7", 1, 1);
    endtask

    task automatic t_refuse();
        do_reset();
        send(mk(1, 0, 3, 1, 0, 1, 0, 0, 0, 0));
        @(negedge clk);
        chk_cmd("R9", 0, 3);
        send(mk(1, 1, 3, 9, 0, 1, 0, 0, 0, 0));
        chk("R9", "first accepted", retry_o, 0);
        send(mk(1, 1, 3, 11, 0, 1, 0, 0, 0, 0));
        chk("R9", "slot full retry", retry_o, 1);
        send(mk(1, 1, 5, 1, 0, 1, 0, 0, 0, 0));
        chk("R9", "bad target retry", retry_o, 1);
        send(mk(1, 6, 2, 1, 0, 1, 0, 0, 0, 0));
        chk("R9", "bad source retry", retry_o, 1);
        @(negedge clk);
        chk("R9", "no cmd", cmd_valid_o, 0);
        done_pulse(3);
        @(negedge clk);
        chk_cmd("R9", 1, 3);
        chk("R9", "kept original total", cmd_total_o, 9);
    endtask

    task automatic t_same_cycle();
        do_reset();
        req_valid_i = 1'b1; req_word_i = mk(1, 0, 0, 10, 0, 1, 0, 0, 0, 0);
        @(negedge clk);
        chk("R10", "first retry", retry_o, 0);
        req_word_i = mk(1, 0, 0, 20, 0, 1, 0, 0, 0, 0);
        @(negedge clk);
        req_valid_i = 1'b0;
        chk_cmd("R10", 0, 0);
        chk("R10", "first total", cmd_total_o, 10);
        chk("R10", "second accepted", retry_o, 0);
        done_pulse(0);
        @(negedge clk);
        chk_cmd("R10", 0, 0);
        chk("R10", "second total", cmd_total_o, 20);
    endtask

    task automatic t_one_per_cycle();
        do_reset();
        send(mk(1, 0, 0, 1, 0, 1, 0, 0, 0, 0));
        send(mk(1, 1, 1, 1, 0, 1, 0, 0, 0, 0));
        send(mk(1, 2, 0, 5, 0, 1, 1, 0, 0, 0));
        send(mk(1, 3, 1, 6, 0, 1, 4, 0, 0, 0));
        @(negedge clk);
        chk("R11", "both busy", chan_en_o, 3);
        done_i = 4'b0011;
        @(negedge clk);
        done_i = '0;
        @(negedge clk);
        chk_cmd("R11", 3, 1);
        chk("R11", "one channel up", chan_en_o, 2);
        @(negedge clk);
        chk_cmd("R11", 2, 0);
        chk("R11", "both up", chan_en_o, 3);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_parity();
        t_max_len();
        t_priority();
        t_refuse();
        t_same_cycle();
        t_one_per_cycle();
        if (!ended) begin
            ended = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule